// File: doc/BRIEF.md
# Go-Back-N Retransmitting Sender

This block is the transmit side of a sliding-window link that recovers lost packets by going back and repeating them. An upstream source offers packets. The block stores each one under its sequence number and sends it downstream once, tagged with that number. Up to four packets can be in flight without an acknowledgement.

The far end returns acknowledgements. Each one carries a sequence number and a flag that marks it as positive or negative. Both kinds are cumulative: they release every buffered packet up to and including the number they carry. A negative acknowledgement also reports a loss after that number. A loss is also assumed when no progress is seen for a fixed number of clock cycles. After either kind of loss, the sender moves its send pointer back to the oldest packet not yet acknowledged and repeats that packet and every later one.

Top module: `gbn_tx_ctrl`

## Requirements
- R1: Once reset is released, `in_ready` is 1 and `out_valid` is 0.
- R2: Accepted packets leave on `out_*` in the order they were accepted, with unchanged data. Sequence numbers are 3 bits wide, start at 0 and wrap from 7 back to 0.
- R3: At most WIN (4) packets are held unacknowledged. With four outstanding, `in_ready` is 0. A packet offered in that state is not taken and never appears on the output.
- R4: A positive acknowledgement (`ack_neg`=0) for n, where n was sent and is not yet acknowledged, releases n and every older packet. New packets are then accepted into the freed slots.
- R5: A negative acknowledgement (`ack_neg`=1) for a valid n releases packets up to n. Transmission then restarts at once from n+1 and repeats every later buffered packet in order.
- R6: If TIMEOUT cycles pass with packets outstanding and no acknowledgement or retransmission start, the block resends everything from the oldest unacknowledged packet.
- R7: An acknowledgement for a number that was never sent, or that is already acknowledged, has no effect. There is no rewind and no release.
- R8: The timeout counter is stopped while no packet is outstanding, so an idle block sends nothing.
- R9: An acknowledgement that arrives during a rewind still takes effect. Packets it covers are skipped, not resent.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_seq` and `out_data` hold steady unless an acknowledgement or timeout arrives in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Upstream offers a packet |
| in_data | input | DATA_W | Upstream packet payload |
| in_ready | output | 1 | A buffer slot is free (usable window not empty) |
| out_valid | output | 1 | A packet is presented downstream |
| out_data | output | DATA_W | Payload of the presented packet |
| out_seq | output | 3 | Sequence number of the presented packet |
| out_ready | input | 1 | Downstream takes the packet this cycle |
| ack_valid | input | 1 | An acknowledgement is presented |
| ack_seq | input | 3 | Cumulative acknowledgement number |
| ack_neg | input | 1 | 1 = negative acknowledgement (loss after ack_seq) |

## Verification
The embedded assertions check several properties on every cycle. The outstanding count never exceeds the window. The high-water send mark only moves forward by one. A valid acknowledgement places the window base just past its number, and a negative one also puts the send pointer there. A timeout never fires while idle. A stalled output holds still. Only the bench scenarios can show the order and content of what is resent: the rewind after a negative acknowledgement, the gap of about TIMEOUT cycles before a timeout resend, the skipping of packets acknowledged during a rewind, and the fact that ignored acknowledgements and refused packets leave no trace on the output.

// File: rtl/gbn_tx_pkg.sv
// Shared sequence-number type for the Go-Back-N sender.
// Assumes 3-bit sequence numbers, which must exceed the window size.
package gbn_tx_pkg;
    localparam int SEQ_W = 3;
    typedef logic [SEQ_W-1:0] seq_t;

    // Modular distance from b forward to a
    function automatic seq_t seq_dist(input seq_t a, input seq_t b);
        return seq_t'(a - b);
    endfunction
endpackage

// File: rtl/gbn_tx_buf.sv
// Packet store indexed by the low bits of the sequence number.
// Assumes DEPTH is a power of two and that a write never targets a slot
// that is still waiting to be sent or acknowledged.
module gbn_tx_buf #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot [DEPTH];

    // Store an accepted packet
    always_ff @(posedge clk) begin
        if (wr_en) slot[wr_addr] <= wr_data;
    end

    // Present the slot chosen by the send pointer
    assign rd_data = slot[rd_addr];
endmodule

// File: rtl/gbn_tx_timer.sv
// Loss timer: counts cycles while packets are outstanding and raises
// expire after TIMEOUT cycles without a restart.
// Assumes TIMEOUT >= 2.
module gbn_tx_timer #(
    parameter int TIMEOUT = 64,
    localparam int TW     = $clog2(TIMEOUT) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic restart,
    output logic expire
);
    logic [TW-1:0] tick;

    assign expire = busy && (tick == TW'(TIMEOUT - 1));

    // Count while busy; clear on restart, expiry or idle
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !busy || expire) tick <= '0;
        else                                      tick <= tick + 1'b1;
    end
endmodule

// File: rtl/gbn_tx_window.sv
// Window pointers of the sender: oldest unacknowledged (base), next to
// send (send_ptr), one past the highest ever sent (sent_hi) and next free
// number (next_new). Applies acknowledgements and rewinds on loss.
// Assumes WIN < 2**SEQ_W.
module gbn_tx_window
    import gbn_tx_pkg::*;
#(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_fire,
    input  logic out_fire,
    input  logic ack_valid,
    input  seq_t ack_seq,
    input  logic ack_neg,
    input  logic expire,
    output seq_t next_new,
    output seq_t send_ptr,
    output logic in_ready,
    output logic out_valid,
    output logic busy,
    output logic restart
);
    seq_t base, sent_hi;
    seq_t held, hi_off, sp_off, ack_off;
    seq_t base_n, sp_n, hi_n;
    logic ack_ok;
    logic [SEQ_W:0] sp_adv, ack_end;

    // Offsets measured from the window base
    always_comb begin
        held    = seq_dist(next_new, base);
        hi_off  = seq_dist(sent_hi, base);
        sp_off  = seq_dist(send_ptr, base);
        ack_off = seq_dist(ack_seq, base);
    end

    assign ack_ok    = ack_valid && (ack_off < hi_off);
    assign in_ready  = (int'(held) < WIN);
    assign out_valid = (send_ptr != next_new);
    assign busy      = (base != sent_hi);
    assign restart   = ack_ok || expire;
    assign sp_adv    = {1'b0, sp_off} + (SEQ_W+1)'(out_fire);
    assign ack_end   = {1'b0, ack_off} + 1'b1;

    // Next pointer values after send, acknowledgement and loss
    always_comb begin
        base_n = ack_ok ? seq_t'(ack_seq + 1'b1) : base;
        sp_n   = seq_t'(send_ptr + out_fire);
        if (ack_ok && (ack_neg || ack_end > sp_adv)) sp_n = seq_t'(ack_seq + 1'b1);
        if (expire) sp_n = base_n;
        hi_n = (out_fire && send_ptr == sent_hi) ? seq_t'(sent_hi + 1'b1) : sent_hi;
    end

    // Pointer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base     <= '0;
            sent_hi  <= '0;
            send_ptr <= '0;
            next_new <= '0;
        end else begin
            base     <= base_n;
            sent_hi  <= hi_n;
            send_ptr <= sp_n;
            next_new <= seq_t'(next_new + in_fire);
        end
    end

    // R3
    win_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(seq_dist(sent_hi, base)) <= WIN);
    // R2
    hi_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sent_hi == $past(sent_hi) || sent_hi == seq_t'($past(sent_hi) + 1'b1));
    // R4
    base_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |=> base == seq_t'($past(ack_seq) + 1'b1));
    // R5
    neg_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok && ack_neg && !expire |=> send_ptr == seq_t'($past(ack_seq) + 1'b1));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> sent_hi != base);
endmodule

// File: rtl/gbn_tx_ctrl.sv
// Go-Back-N transmit controller: buffers up to WIN packets, sends each
// once, and resends from the oldest unacknowledged packet after a
// negative acknowledgement or a timeout.
// Assumes WIN is a power of two below 8 and TIMEOUT >= 2.
module gbn_tx_ctrl
    import gbn_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int WIN     = 4,
    parameter int TIMEOUT = 64,
    localparam int AW     = $clog2(WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [2:0]        out_seq,
    input  logic              out_ready,
    input  logic              ack_valid,
    input  logic [2:0]        ack_seq,
    input  logic              ack_neg
);
    seq_t next_new, send_ptr;
    logic busy, restart, expire;
    logic in_fire, out_fire;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;
    assign out_seq  = send_ptr;

    gbn_tx_window #(.WIN(WIN)) u_win (
        .clk(clk), .rst_n(rst_n), .in_fire(in_fire), .out_fire(out_fire),
        .ack_valid(ack_valid), .ack_seq(ack_seq), .ack_neg(ack_neg),
        .expire(expire), .next_new(next_new), .send_ptr(send_ptr),
        .in_ready(in_ready), .out_valid(out_valid), .busy(busy),
        .restart(restart)
    );

    gbn_tx_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .busy(busy), .restart(restart),
        .expire(expire)
    );

    gbn_tx_buf #(.DEPTH(WIN), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .wr_en(in_fire), .wr_addr(next_new[AW-1:0]),
        .wr_data(in_data), .rd_addr(send_ptr[AW-1:0]), .rd_data(out_data)
    );

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !ack_valid && !expire |=>
        out_valid && $stable(out_seq) && $stable(out_data));
endmodule

// File: tb/sim_gbn_tx_ctrl.sv
module sim_gbn_tx_ctrl;
    localparam int T = 20;
    logic clk = 0, rst_n = 0;
    logic in_valid = 0, out_ready = 1, ack_valid = 0, ack_neg = 0;
    logic [7:0] in_data = 0;
    logic [2:0] ack_seq = 0;
    logic in_ready, out_valid;
    logic [7:0] out_data;
    logic [2:0] out_seq;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [2:0] exp_seq[$];
    logic [7:0] exp_dat[$];
    string exp_tag[$];
    int pop_cyc[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gbn_tx_ctrl #(.DATA_W(8), .WIN(4), .TIMEOUT(T)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_seq(out_seq), .out_ready(out_ready), .ack_valid(ack_valid),
        .ack_seq(ack_seq), .ack_neg(ack_neg)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_pkt(input logic [2:0] s, input logic [7:0] d, input string tag);
        exp_seq.push_back(s); exp_dat.push_back(d); exp_tag.push_back(tag);
    endtask

    task automatic push(input logic [7:0] d);
        @(posedge clk); #1 in_valid = 1; in_data = d;
        @(posedge clk); #1 in_valid = 0;
    endtask

    task automatic ack(input logic [2:0] s, input logic neg);
        @(posedge clk); #1 ack_valid = 1; ack_seq = s; ack_neg = neg;
        @(posedge clk); #1 ack_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Monitor: compare each sent packet with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_seq.size() == 0) begin
                chk(0, "R7/R8 unexpected send seq", int'(out_seq), -1);
            end else begin
                chk(out_seq == exp_seq[0] && out_data == exp_dat[0],
                    {exp_tag[0], " seq/data"}, {out_seq, out_data}, {exp_seq[0], exp_dat[0]});
                void'(exp_seq.pop_front()); void'(exp_dat.pop_front());
                void'(exp_tag.pop_front());
                pop_cyc.push_back(cyc);
            end
        end
    end

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        int gap;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(in_ready == 1, "R1 in_ready", in_ready, 1);
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);

        // R2 R3: fill the window
        for (int i = 0; i < 4; i++) begin
            expect_pkt(3'(i), 8'hA0 + 8'(i), "R2");
            push(8'hA0 + 8'(i));
        end
        idle(4); @(negedge clk);
        chk(exp_seq.size() == 0, "R2 all sent", exp_seq.size(), 0);
        chk(in_ready == 0, "R3 full", in_ready, 0);
        @(posedge clk); #1 in_valid = 1; in_data = 8'hEE;
        @(posedge clk); #1 in_valid = 0;

        // R4: release 0..1, new packets go to seq 4,5
        ack(3'd1, 0);
        @(negedge clk);
        chk(in_ready == 1, "R4 slot freed", in_ready, 1);
        expect_pkt(3'd4, 8'hB4, "R3 refused pkt absent");
        expect_pkt(3'd5, 8'hB5, "R4");
        push(8'hB4); push(8'hB5);
        idle(4);

        // R5: negative ack 3 -> resend 4,5
        expect_pkt(3'd4, 8'hB4, "R5");
        expect_pkt(3'd5, 8'hB5, "R5");
        ack(3'd3, 1);
        idle(4); @(negedge clk);
        chk(exp_seq.size() == 0, "R5 rewind done", exp_seq.size(), 0);

        // R7: never-sent and stale acks do nothing
        ack(3'd7, 1);
        ack(3'd3, 1);
        ack(3'd2, 0);
        idle(3); @(negedge clk);
        chk(exp_seq.size() == 0, "R7 no resend", exp_seq.size(), 0);

        // R6: timeout resend of 4,5
        expect_pkt(3'd4, 8'hB4, "R6");
        expect_pkt(3'd5, 8'hB5, "R6");
        for (int k = 0; k < 3*T && exp_seq.size() != 0; k++) @(negedge clk);
        chk(exp_seq.size() == 0, "R6 timeout resend", exp_seq.size(), 0);
        gap = pop_cyc[pop_cyc.size()-2] - pop_cyc[pop_cyc.size()-4];
        chk(gap >= T-1 && gap <= T+1, "R6 timeout gap", gap, T);
        ack(3'd5, 0);

        // R8: idle, nothing outstanding, nothing sent
        idle(3*T); @(negedge clk);
        chk(out_valid == 0, "R8 idle", out_valid, 0);
        chk(in_ready == 1, "R8 in_ready", in_ready, 1);

        // R2 R9: seq 6,7,0,1 with wrap, then ack during rewind
        for (int i = 0; i < 4; i++) begin
            expect_pkt(3'(6 + i), 8'hC0 + 8'(i), "R2 wrap");
            push(8'hC0 + 8'(i));
        end
        idle(4);
        #1 out_ready = 0;
        ack(3'd6, 1);
        ack(3'd0, 0);
        @(negedge clk);
        chk(out_valid == 1 && out_seq == 3'd1, "R9 skip to seq", out_seq, 1);
        expect_pkt(3'd1, 8'hC3, "R9");
        @(posedge clk); #1 out_ready = 1;
        idle(3);
        ack(3'd1, 0);
        idle(2); @(negedge clk);
        chk(exp_seq.size() == 0, "R9 only seq1 resent", exp_seq.size(), 0);
        chk(out_valid == 0, "R9 drained", out_valid, 0);
        chk(in_ready == 1, "R4 all free", in_ready, 1);
        summary();
    end
endmodule